// File: doc/BRIEF.md
# Two-Level Interrupt Enable Controller

This block collects interrupt requests and presents them to a processor as two request lines, one urgent and one normal. Its inputs are three external pins and a generic bus of peripheral interrupt sources, each source having a flag, an enable and a priority bit. One byte-wide control register holds a master enable, an enable for the normal level, a switch that turns priority levels on or off, and a per-pin choice of which edge of each external pin raises its flag.

Each external pin goes through a synchroniser, and an edge detector compares successive synchronised samples. On the chosen edge the detector sets a sticky flag. Software clears the flag by writing 0 to its bit. When priority levels are off, every enabled source goes to the urgent line, gated only by the master enable. When they are on, a source's priority bit picks its line, and the normal line also needs its own enable. Both request outputs are registered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the control register reads 0x07, all external flags are 0 and both request outputs are 0.
- R2: Control bit layout: bit 7 master enable, bit 6 normal-level enable, bit 5 priority-mode switch, bits 2..0 edge selects for pins 2..0. Bits 4 and 3 always read 0, and writes to them have no effect.
- R3: While bit 5 reads 0, bit 6 reads 0. The value last written to bit 6 is kept, and it reads back once bit 5 is set.
- R4: With edge select 1, a rising pin edge sets that pin's flag. The flag becomes visible on the third rising clock edge after the pin changes (two synchroniser stages plus the flag register). A falling edge sets nothing.
- R5: With edge select 0, a falling pin edge sets the flag with the same latency. A rising edge sets nothing.
- R6: Changing an edge-select bit while a pin holds a steady level does not set a flag.
- R7: A flag stays set until a write to the flag clear port carries 0 in that bit. A 1 in the written bit leaves the flag unchanged.
- R8: With priority mode off and bit 7 set, any source that is flagged and enabled raises the urgent output whatever its priority bit is. The normal output stays 0.
- R9: With priority mode on and bit 7 set, a flagged and enabled source whose priority bit is 1 raises the urgent output.
- R10: With priority mode on, a flagged and enabled source whose priority bit is 0 raises the normal output only when bits 7 and 6 are both set.
- R11: While the urgent output is raised, the normal output is held at 0.
- R12: With bit 7 clear, both outputs are 0 in either mode. Outputs follow their inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read-back |
| ext_pin | input | 3 | External interrupt pins (asynchronous) |
| ext_en | input | 3 | Enables for the external sources |
| ext_prio | input | 3 | Priority bits for the external sources (1 = urgent) |
| ext_flag_we | input | 1 | Write strobe for the external flags |
| ext_flag_wdata | input | 3 | Flag write data; a 0 clears that flag |
| ext_flag | output | 3 | External interrupt flags |
| per_flag | input | PERIPH_SRCS | Peripheral interrupt flags |
| per_en | input | PERIPH_SRCS | Peripheral enables |
| per_prio | input | PERIPH_SRCS | Peripheral priority bits (1 = urgent) |
| irq_hi | output | 1 | Urgent-level request |
| irq_lo | output | 1 | Normal-level request |

## Verification
The bench measures the flag latency exactly: the flag must be 0 after two clocks and 1 after three. A synchroniser that is too short or too long therefore fails. It changes edge selects while the pins are held high and low, and a detector that compares against the select bit instead of against the previous sample would raise a spurious flag there. It switches priority mode with normal-level sources pending. A design that ignores the mode would route them to the wrong output or leave bit 6 visible. It also pends urgent and normal sources together, so missing suppression shows up as both outputs high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 8;
  localparam int EXT_PINS = 3;
  localparam int B_MASTER = 7;
  localparam int B_NORMAL = 6;
  localparam int B_PMODE  = 5;
  localparam logic [EXT_PINS-1:0] EDGE_RST = '1;

  typedef struct packed {
    logic                master_en;
    logic                normal_en;
    logic                pmode;
    logic [EXT_PINS-1:0] rise_sel;
  } ctl_t;
endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rdata
);
  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q.master_en <= 1'b0;
      ctl_q.normal_en <= 1'b0;
      ctl_q.pmode     <= 1'b0;
      ctl_q.rise_sel  <= EDGE_RST;
    end else if (we) begin
      ctl_q.master_en <= wdata[B_MASTER];
      ctl_q.normal_en <= wdata[B_NORMAL];
      ctl_q.pmode     <= wdata[B_PMODE];
      ctl_q.rise_sel  <= wdata[EXT_PINS-1:0];
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[B_MASTER]       = ctl_q.master_en;
    rdata[B_NORMAL]       = ctl_q.normal_en & ctl_q.pmode;
    rdata[B_PMODE]        = ctl_q.pmode;
    rdata[EXT_PINS-1:0]   = ctl_q.rise_sel;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  input  logic clr,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   flag_q;
  logic                   cur;
  logic                   hit;

  assign cur = sync_q[SYNC_STAGES-1];
  assign hit = rise_sel ? (cur & ~last_q) : (~cur & last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= cur;
      flag_q <= hit | (flag_q & ~clr);
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import irq_pkg::*;
#(
  parameter int SRCS = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_t            ctl,
  input  logic [SRCS-1:0] src_flag,
  input  logic [SRCS-1:0] src_en,
  input  logic [SRCS-1:0] src_prio,
  output logic            irq_hi,
  output logic            irq_lo
);
  logic [SRCS-1:0] active;
  logic [SRCS-1:0] as_urgent;
  logic            hi_d;
  logic            lo_d;
  logic            hi_q;
  logic            lo_q;

  assign active    = src_flag & src_en;
  assign as_urgent = src_prio | {SRCS{~ctl.pmode}};

  always_comb begin
    hi_d = ctl.master_en & (|(active & as_urgent));
    lo_d = ctl.master_en & ctl.normal_en & ctl.pmode
         & (|(active & ~src_prio)) & ~hi_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign irq_hi = hi_q;
  assign irq_lo = lo_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int PERIPH_SRCS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_we,
  input  logic [REG_W-1:0]       ctl_wdata,
  output logic [REG_W-1:0]       ctl_rdata,
  input  logic [EXT_PINS-1:0]    ext_pin,
  input  logic [EXT_PINS-1:0]    ext_en,
  input  logic [EXT_PINS-1:0]    ext_prio,
  input  logic                   ext_flag_we,
  input  logic [EXT_PINS-1:0]    ext_flag_wdata,
  output logic [EXT_PINS-1:0]    ext_flag,
  input  logic [PERIPH_SRCS-1:0] per_flag,
  input  logic [PERIPH_SRCS-1:0] per_en,
  input  logic [PERIPH_SRCS-1:0] per_prio,
  output logic                   irq_hi,
  output logic                   irq_lo
);
  localparam int SRCS = PERIPH_SRCS + EXT_PINS;

  ctl_t                ctl;
  logic [EXT_PINS-1:0] flag_w;

  irq_ctl_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .ctl   (ctl),
    .rdata (ctl_rdata)
  );

  for (genvar i = 0; i < EXT_PINS; i++) begin : g_pin
    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk      (clk),
      .rst      (rst),
      .pin      (ext_pin[i]),
      .rise_sel (ctl.rise_sel[i]),
      .clr      (ext_flag_we & ~ext_flag_wdata[i]),
      .flag     (flag_w[i])
    );
  end

  irq_req_gate #(.SRCS(SRCS)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .src_flag ({per_flag, flag_w}),
    .src_en   ({per_en, ext_en}),
    .src_prio ({per_prio, ext_prio}),
    .irq_hi   (irq_hi),
    .irq_lo   (irq_lo)
  );

  assign ext_flag = flag_w;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [REG_W-1:0]    ctl_rdata,
  input logic                ext_flag_we,
  input logic [EXT_PINS-1:0] ext_flag_wdata,
  input logic [EXT_PINS-1:0] ext_flag,
  input logic                irq_hi,
  input logic                irq_lo
);
  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[4:3] == 2'b00);

  // R3
  normal_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[B_PMODE] |-> !ctl_rdata[B_NORMAL]);

  // R11
  lines_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_hi && irq_lo));

  // R12
  hi_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(ctl_rdata[B_MASTER]));

  // R10
  lo_needs_all_chk: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(ctl_rdata[B_MASTER] && ctl_rdata[B_NORMAL] && ctl_rdata[B_PMODE]));

  for (genvar i = 0; i < EXT_PINS; i++) begin : g_flag
    // R7
    flag_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ext_flag[i]) |-> $past(ext_flag_we && !ext_flag_wdata[i]));
  end
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .ctl_rdata      (ctl_rdata),
  .ext_flag_we    (ext_flag_we),
  .ext_flag_wdata (ext_flag_wdata),
  .ext_flag       (ext_flag),
  .irq_hi         (irq_hi),
  .irq_lo         (irq_lo)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    ctl_rdata;
  logic [2:0]    ext_pin = '0;
  logic [2:0]    ext_en = '0;
  logic [2:0]    ext_prio = '0;
  logic          ext_flag_we = 1'b0;
  logic [2:0]    ext_flag_wdata = '0;
  logic [2:0]    ext_flag;
  logic [NP-1:0] per_flag = '0;
  logic [NP-1:0] per_en = '0;
  logic [NP-1:0] per_prio = '0;
  logic          irq_hi;
  logic          irq_lo;

  int checks = 0;
  int errors = 0;

  irq_prio_ctrl #(.PERIPH_SRCS(NP)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step(1);
    ctl_we = 1'b0;
  endtask

  task automatic wr_flag(input logic [2:0] v);
    ext_flag_we = 1'b1; ext_flag_wdata = v;
    step(1);
    ext_flag_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_rdata, 8'h07);
    chk("R1 flags", ext_flag, 3'b000);
    chk("R1 irq", {irq_hi, irq_lo}, 2'b00);
  endtask

  task automatic t_readback();
    wr_ctl(8'hFF);
    chk("R2 all ones pmode on", ctl_rdata, 8'hE7);
    wr_ctl(8'hDA);
    chk("R3 bit6 hidden", ctl_rdata, 8'h82);
    wr_ctl(8'h38);
    chk("R2 bits4:3 ignored", ctl_rdata, 8'h20);
    wr_ctl(8'h47);
    chk("R3 bit6 hidden pmode off", ctl_rdata, 8'h07);
    wr_ctl(8'h67);
    chk("R3 bit6 visible pmode on", ctl_rdata, 8'h67);
    wr_ctl(8'h07);
  endtask

  task automatic t_rise();
    wr_ctl(8'h07);
    ext_pin[0] = 1'b1;
    step(2);
    chk("R4 not yet after 2", ext_flag, 3'b000);
    step(1);
    chk("R4 rising sets flag", ext_flag, 3'b001);
    wr_flag(3'b110);
    chk("R7 clear flag", ext_flag, 3'b000);
    ext_pin[0] = 1'b0;
    step(4);
    chk("R4 falling ignored", ext_flag, 3'b000);
  endtask

  task automatic t_fall();
    wr_ctl(8'h05);
    ext_pin[1] = 1'b1;
    step(4);
    chk("R5 rising ignored", ext_flag, 3'b000);
    ext_pin[1] = 1'b0;
    step(2);
    chk("R5 not yet after 2", ext_flag, 3'b000);
    step(1);
    chk("R5 falling sets flag", ext_flag, 3'b010);
    wr_flag(3'b111);
    chk("R7 write 1 keeps flag", ext_flag, 3'b010);
    step(3);
    chk("R7 flag sticky", ext_flag, 3'b010);
    wr_flag(3'b101);
    chk("R7 write 0 clears", ext_flag, 3'b000);
  endtask

  task automatic t_sel_change();
    ext_pin = 3'b101;
    wr_ctl(8'h00);
    step(4);
    wr_flag(3'b000);
    chk("R6 setup clear", ext_flag, 3'b000);
    wr_ctl(8'h07);
    step(4);
    chk("R6 select to rise", ext_flag, 3'b000);
    wr_ctl(8'h00);
    step(4);
    chk("R6 select to fall", ext_flag, 3'b000);
    ext_pin = 3'b000;
    step(4);
    wr_flag(3'b000);
    wr_ctl(8'h07);
  endtask

  task automatic t_nopri();
    per_en = 8'h10; per_prio = 8'h00; per_flag = 8'h10;
    wr_ctl(8'hC7);
    step(1);
    chk("R8 prio0 goes urgent", {irq_hi, irq_lo}, 2'b10);
    per_prio = 8'h10;
    step(1);
    chk("R8 prio1 urgent", {irq_hi, irq_lo}, 2'b10);
    per_en = 8'h00;
    step(1);
    chk("R8 masked source", {irq_hi, irq_lo}, 2'b00);
    per_en = 8'h10;
    wr_ctl(8'h47);
    step(1);
    chk("R12 master off nopri", {irq_hi, irq_lo}, 2'b00);
  endtask

  task automatic t_pri();
    per_flag = 8'h01; per_en = 8'h01; per_prio = 8'h00;
    wr_ctl(8'hE7);
    step(1);
    chk("R10 normal line", {irq_hi, irq_lo}, 2'b01);
    wr_ctl(8'hA7);
    step(1);
    chk("R10 needs bit6", {irq_hi, irq_lo}, 2'b00);
    wr_ctl(8'h67);
    step(1);
    chk("R12 master off pri", {irq_hi, irq_lo}, 2'b00);
    wr_ctl(8'hE7);
    per_prio = 8'h01;
    step(1);
    chk("R9 urgent in pri mode", {irq_hi, irq_lo}, 2'b10);
    per_flag = 8'h03; per_en = 8'h03; per_prio = 8'h02;
    step(1);
    chk("R11 urgent suppresses normal", {irq_hi, irq_lo}, 2'b10);
    per_flag = 8'h01;
    step(1);
    chk("R11 normal after urgent gone", {irq_hi, irq_lo}, 2'b01);
    per_flag = 8'h00;
    step(1);
    chk("R12 latency idle", {irq_hi, irq_lo}, 2'b00);
    per_flag = 8'h01;
    #1;
    chk("R12 no same-cycle change", {irq_hi, irq_lo}, 2'b00);
    per_flag = 8'h00; per_en = 8'h00; per_prio = 8'h00;
  endtask

  task automatic t_ext_pri();
    ext_en = 3'b100; ext_prio = 3'b100;
    wr_ctl(8'hE7);
    ext_pin[2] = 1'b1;
    step(3);
    chk("R4 pin2 flag", ext_flag, 3'b100);
    step(1);
    chk("R9 ext pin urgent", {irq_hi, irq_lo}, 2'b10);
    ext_pin[2] = 1'b0;
    wr_flag(3'b000);
    step(1);
    chk("R7 cleared drops request", {irq_hi, irq_lo}, 2'b00);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_readback();
    t_rise();
    t_fall();
    t_sel_change();
    t_nopri();
    t_pri();
    t_ext_pri();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule